// File: doc/BRIEF.md
# Read Capture Delay and Roundtrip Timer

This block models the receive-side timing of a group of DRAM read lanes. A read command starts a roundtrip countdown. The countdown is loaded from a programmable roundtrip register that counts in data-clock cycles. When the count reaches zero, the input capture window opens. Each lane then waits its own extra delay before it latches one strobe sample as a single result bit.

A lane's extra delay is made of two settings. The first is a whole-cycle delay. The second is a 9-bit phase code in steps of 1/64 of a cycle. The upper three phase bits are whole cycles and add to the cycle delay. The lower six bits pick one of 64 sub-cycle taps from that lane's sampled strobe vector. A one-cycle valid pulse presents the result bits once every lane has captured. Training logic uses it by sweeping the delays, issuing reads and inspecting the returned bits.

Top module: `readCaptureTimer`

## Requirements
- R1: After reset, `busy` and `resultValid` are low, and the roundtrip register holds 55.
- R2: A `readCmd` sampled high while `busy` is low is accepted. It loads the roundtrip register into the countdown, and `busy` is high from the next cycle until the result is presented.
- R3: For a read accepted at clock edge t0 with roundtrip value RT, lane l captures at edge t0+RT+2+D, where D = cycle delay + phase code bits [8:6].
- R4: The captured bit of lane l is bit (l*64 + phase code bits [5:0]) of `strobeTaps`, taken from the value present at the capture edge.
- R5: Raising a lane's phase code by 64 gives the same capture edge and tap as raising its cycle delay by one.
- R6: A `readCmd` that arrives while `busy` is high is ignored. It neither restarts nor extends the current read.
- R7: `resultValid` is a one-cycle pulse that appears after the edge of the last lane's capture (edge t0+RT+2+max D). `busy` falls in the same cycle.
- R8: A write to the roundtrip register (`rtWrEn`) takes effect from the next accepted read. A read already in progress keeps the value it loaded.
- R9: `resultBits` carries exactly one captured bit per lane, with bit l belonging to lane l, and is valid while `resultValid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rstN | input | 1 | Asynchronous active-low reset |
| readCmd | input | 1 | Read command strobe |
| rtWrEn | input | 1 | Roundtrip register write enable |
| rtWrData | input | RT_W (8) | Roundtrip value in cycles |
| cycleDelay | input | LANES*CDLY_W (16) | Per-lane whole-cycle delay, lane l at [l*CDLY_W +: CDLY_W] |
| phaseCode | input | LANES*9 (36) | Per-lane phase code, lane l at [l*9 +: 9] |
| strobeTaps | input | LANES*64 (256) | Per-lane sub-cycle strobe samples, lane l at [l*64 +: 64] |
| busy | output | 1 | A read is in progress |
| resultValid | output | 1 | One-cycle result strobe |
| resultBits | output | LANES (4) | One captured strobe bit per lane |

## Verification
The main overlap is at the end of a read. The result pulse and the acceptance of the next read can fall in the same cycle, because `busy` drops together with `resultValid`. The bench holds `readCmd` high through two consecutive reads. It expects the second acceptance at the edge right after the valid pulse is shown, so the two pulses are one read length plus one cycle apart. A second overlap occurs when a roundtrip write arrives while a read is counting down. The bench checks that the current latency keeps the old value and that the next read uses the new one.

// File: rtl/rcdPkg.sv
package rcdPkg;
  parameter int unsigned PH_W  = 9;
  parameter int unsigned TAP_W = 6;
  parameter int unsigned TAPS  = 1 << TAP_W;
  parameter int unsigned WIN_W = 6;

  typedef struct packed {
    logic             windowOpen;
    logic [WIN_W-1:0] winIdx;
    logic             finish;
  } captureCtl_t;
endpackage

// File: rtl/rcdCtrl.sv
module rcdCtrl
  import rcdPkg::*;
#(
  parameter int unsigned RT_W     = 8,
  parameter int unsigned RT_RESET = 55
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             readCmd,
  input  logic             rtWrEn,
  input  logic [RT_W-1:0]  rtWrData,
  input  logic [WIN_W-1:0] lastOff,
  output logic             busy,
  output captureCtl_t      ctl
);
  typedef enum logic [1:0] {S_IDLE, S_COUNT, S_WIN} state_t;

  state_t           state;
  logic [RT_W-1:0]  rtReg;
  logic [RT_W-1:0]  cnt;
  logic [WIN_W-1:0] win;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rtReg <= RT_W'(RT_RESET);
    end else if (rtWrEn) begin
      rtReg <= rtWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      win   <= '0;
    end else begin
      case (state)
        S_IDLE: if (readCmd) begin
          cnt   <= rtReg;
          state <= S_COUNT;
        end
        S_COUNT: if (cnt == '0) begin
          state <= S_WIN;
          win   <= '0;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_WIN: if (win == lastOff) begin
          state <= S_IDLE;
        end else begin
          win <= win + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.windowOpen = (state == S_WIN);
    ctl.winIdx     = win;
    ctl.finish     = (state == S_WIN) && (win == lastOff);
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/rcdDatapath.sv
module rcdDatapath
  import rcdPkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned CDLY_W = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  captureCtl_t             ctl,
  input  logic [LANES*CDLY_W-1:0] cycleDelay,
  input  logic [LANES*PH_W-1:0]   phaseCode,
  input  logic [LANES*TAPS-1:0]   strobeTaps,
  output logic [WIN_W-1:0]        lastOff,
  output logic                    resultValid,
  output logic [LANES-1:0]        resultBits
);
  localparam int unsigned CYC_HI = PH_W - TAP_W;

  logic [WIN_W-1:0] laneOff [LANES];
  logic [TAP_W-1:0] laneTap [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [PH_W-1:0] ph;
    assign ph         = phaseCode[l*PH_W +: PH_W];
    assign laneTap[l] = ph[TAP_W-1:0];
    assign laneOff[l] = WIN_W'(cycleDelay[l*CDLY_W +: CDLY_W])
                      + WIN_W'(ph[PH_W-1 -: CYC_HI]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        resultBits[l] <= 1'b0;
      end else if (ctl.windowOpen && ctl.winIdx == laneOff[l]) begin
        resultBits[l] <= strobeTaps[l*TAPS + int'(laneTap[l])];
      end
    end
  end

  always_comb begin
    lastOff = '0;
    for (int l = 0; l < LANES; l++) begin
      if (laneOff[l] > lastOff) lastOff = laneOff[l];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resultValid <= 1'b0;
    else       resultValid <= ctl.finish;
  end
endmodule

// File: rtl/readCaptureTimer.sv
module readCaptureTimer
  import rcdPkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned CDLY_W = 4,
  parameter int unsigned RT_W   = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    readCmd,
  input  logic                    rtWrEn,
  input  logic [RT_W-1:0]         rtWrData,
  input  logic [LANES*CDLY_W-1:0] cycleDelay,
  input  logic [LANES*PH_W-1:0]   phaseCode,
  input  logic [LANES*TAPS-1:0]   strobeTaps,
  output logic                    busy,
  output logic                    resultValid,
  output logic [LANES-1:0]        resultBits
);
  captureCtl_t      ctl;
  logic [WIN_W-1:0] lastOff;

  rcdCtrl #(.RT_W(RT_W), .RT_RESET(55)) u_ctrl (
    .clk(clk), .rstN(rstN), .readCmd(readCmd), .rtWrEn(rtWrEn),
    .rtWrData(rtWrData), .lastOff(lastOff), .busy(busy), .ctl(ctl)
  );

  rcdDatapath #(.LANES(LANES), .CDLY_W(CDLY_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cycleDelay(cycleDelay),
    .phaseCode(phaseCode), .strobeTaps(strobeTaps), .lastOff(lastOff),
    .resultValid(resultValid), .resultBits(resultBits)
  );
endmodule

// File: rtl/rcdChecker.sv
module rcdChecker (
  input logic clk,
  input logic rstN,
  input logic readCmd,
  input logic busy,
  input logic resultValid
);
  // R1: reset leaves the block idle
  p_reset_idle_r1: assert property (@(posedge clk)
    !rstN |=> (!busy && !resultValid));

  // R2: a read only starts from an accepted command
  p_start_needs_cmd_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(readCmd));

  // R7: the valid strobe lasts exactly one cycle
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R7: busy ends only together with a result
  p_busy_ends_with_result_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> resultValid);

  // R6: a result never appears without a read that was running
  p_valid_from_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resultValid) |-> $past(busy));
endmodule

bind readCaptureTimer rcdChecker u_rcdChecker (
  .clk(clk), .rstN(rstN), .readCmd(readCmd), .busy(busy),
  .resultValid(resultValid)
);

// File: tb/test_readCaptureTimer.sv
module test_readCaptureTimer;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int CDLY_W = 4;
  localparam int RT_W = 8;

  logic clk = 0;
  logic rstN = 0;
  logic readCmd = 0;
  logic rtWrEn = 0;
  logic [RT_W-1:0] rtWrData = '0;
  logic [LANES*CDLY_W-1:0] cycleDelay;
  logic [LANES*9-1:0] phaseCode;
  logic [LANES*64-1:0] strobeTaps = '0;
  logic busy, resultValid;
  logic [LANES-1:0] resultBits;

  int cycArr [LANES];
  int phArr [LANES];
  int vectors = 0;
  int fails = 0;
  int wd = 0;
  bit armed = 0;
  string curReq = "R2";

  // reference model state
  int rtM = 55, rtA = 0, k = 0;
  bit busyM = 0, validM = 0;
  bit [LANES-1:0] capM = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      cycleDelay[l*CDLY_W +: CDLY_W] = CDLY_W'(cycArr[l]);
      phaseCode[l*9 +: 9] = 9'(phArr[l]);
    end
  end

  readCaptureTimer #(.LANES(LANES), .CDLY_W(CDLY_W), .RT_W(RT_W)) i_readCaptureTimer (
    .clk(clk), .rstN(rstN), .readCmd(readCmd), .rtWrEn(rtWrEn),
    .rtWrData(rtWrData), .cycleDelay(cycleDelay), .phaseCode(phaseCode),
    .strobeTaps(strobeTaps), .busy(busy), .resultValid(resultValid),
    .resultBits(resultBits)
  );

  function automatic int laneOffset(int l);
    return cycArr[l] + (phArr[l] / 64);
  endfunction

  function automatic int maxOffset();
    int m = 0;
    for (int l = 0; l < LANES; l++) if (laneOffset(l) > m) m = laneOffset(l);
    return m;
  endfunction

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      rtM = 55; busyM = 0; validM = 0; capM = '0; k = 0;
    end else begin
      validM = 0;
      if (busyM) begin
        k++;
        for (int l = 0; l < LANES; l++)
          if (k == rtA + 2 + laneOffset(l)) capM[l] = strobeTaps[l*64 + (phArr[l] % 64)];
        if (k == rtA + 2 + maxOffset()) begin
          busyM = 0; validM = 1;
        end
      end else if (readCmd) begin
        busyM = 1; k = 0; rtA = rtM;
      end
      if (rtWrEn) rtM = int'(rtWrData);
    end
  end

  task automatic check(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (armed && rstN) begin
      check(curReq, "busy", int'(busy), int'(busyM));
      check("R7", "resultValid", int'(resultValid), int'(validM));
      if (validM) check("R9", "resultBits", int'(resultBits), int'(capM));
    end
    for (int w = 0; w < LANES*2; w++) strobeTaps[w*32 +: 32] = $urandom;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 100000", wd);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // issue one read; optionally inject a second command or a roundtrip write
  task automatic runRead(input int injectAt, input int wrAt, input int wrVal, output int lat);
    int n = 0;
    @(negedge clk); readCmd = 1;
    @(negedge clk); readCmd = 0;
    while (!resultValid && n < 400) begin
      if (n == injectAt) readCmd = 1;
      if (n == injectAt + 1) readCmd = 0;
      if (n == wrAt) begin rtWrEn = 1; rtWrData = RT_W'(wrVal); end
      if (n == wrAt + 1) rtWrEn = 0;
      @(negedge clk);
      n++;
    end
    readCmd = 0; rtWrEn = 0;
    lat = n;
    @(negedge clk);
  endtask

  task automatic writeRt(int v);
    @(negedge clk); rtWrEn = 1; rtWrData = RT_W'(v);
    @(negedge clk); rtWrEn = 0;
  endtask

  initial begin
    int lat, latA, latB, t1, t2;
    for (int l = 0; l < LANES; l++) begin cycArr[l] = 0; phArr[l] = 0; end
    repeat (3) @(negedge clk);
    check("R1", "busy after reset", int'(busy), 0);
    check("R1", "resultValid after reset", int'(resultValid), 0);
    rstN = 1;
    armed = 1;

    // R1/R3: reset roundtrip of 55, zero lane delays
    curReq = "R3";
    runRead(-10, -10, 0, lat);
    check("R1", "latency with reset roundtrip", lat, 55 + 2);

    // R3/R4: mixed delays and taps
    writeRt(10);
    cycArr = '{3, 0, 5, 2};
    phArr  = '{0, 2*64 + 7, 63, 511};
    curReq = "R4";
    runRead(-10, -10, 0, lat);
    check("R3", "latency mixed delays", lat, 10 + 2 + 9);

    // R5: phase +64 equals cycle delay +1
    curReq = "R5";
    cycArr = '{2, 0, 0, 0}; phArr = '{10, 0, 0, 0};
    runRead(-10, -10, 0, latA);
    cycArr = '{1, 0, 0, 0}; phArr = '{74, 0, 0, 0};
    runRead(-10, -10, 0, latB);
    check("R5", "phase fold latency", latB, latA);
    check("R5", "phase fold absolute", latA, 10 + 2 + 2);

    // R6: command during busy ignored
    curReq = "R6";
    cycArr = '{1, 1, 1, 1}; phArr = '{0, 64, 128, 5};
    runRead(4, -10, 0, lat);
    check("R6", "latency with extra command", lat, 10 + 2 + 3);
    check("R6", "idle after ignored command", int'(busy), 0);

    // R8: roundtrip write during a read
    curReq = "R8";
    runRead(-10, 3, 20, lat);
    check("R8", "current read keeps old roundtrip", lat, 10 + 2 + 3);
    runRead(-10, -10, 0, lat);
    check("R8", "next read uses new roundtrip", lat, 20 + 2 + 3);

    // R2/R7: command held high, back-to-back reads
    curReq = "R2";
    writeRt(4);
    cycArr = '{0, 1, 0, 2}; phArr = '{300, 0, 64, 9};
    @(negedge clk); readCmd = 1;
    t1 = 0;
    while (!resultValid && t1 < 400) begin @(negedge clk); t1++; end
    t2 = 0;
    @(negedge clk);
    while (!resultValid && t2 < 400) begin @(negedge clk); t2++; end
    readCmd = 0;
    check("R7", "back-to-back pulse spacing", t2 + 1, 4 + 2 + 4 + 1);
    repeat (30) @(negedge clk);
    check("R2", "idle at end", int'(busy), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule